// File: doc/BRIEF.md
# DRAM Operating-Current Command Sequencer

This block emits the fixed, endlessly repeating command streams used while the supply current of a DDR SDRAM is measured. Once started it replays a slot pattern, one command per clock. In four-bank mode it interleaves activates and auto-precharge reads across all four banks. In one-bank mode it runs an activate / read / precharge loop on bank 0, and a speed-bin input picks the 9-clock or the 10-clock variant of that loop.

Row and column addresses come from a 16-bit LFSR that steps once per loop, so every repetition uses new addresses. A data word flips exactly half of its bits on every read burst. On no-op slots the address bus is either held (four-bank) or inverted on every clock (one-bank), to match the switching activity each test calls for. A stop request lets the current loop finish, and the bus then rests on no-op.

Top module: `idd_cmd_seq`

## Requirements
- R1: After reset the command pins read no-op (ras_n, cas_n, we_n = 1,1,1), and bank, address and data are all zero.
- R2: When start_i is sampled high while idle, the outputs still show no-op after that edge, and the first activate (bank 0) appears after the following edge. Mode and bin are captured at that start edge.
- R3: With mode_i=1 (four-bank) the 10-slot loop is ACT b0, NOP, ACT b1, RD b0, ACT b2, RD b1, ACT b3, RD b2, NOP, RD b3, repeated. This gives activate spacing 2 and activate-to-read 3.
- R4: With mode_i=0 and bin_i=0 the 9-slot loop is ACT b0, NOP, NOP, RD b0, NOP, NOP, PRE b0, NOP, NOP.
- R5: With mode_i=0 and bin_i=1 the 10-slot loop is ACT b0, NOP, NOP, RD b0, NOP, NOP, NOP, PRE b0, NOP, NOP.
- R6: Command encoding on {ras_n, cas_n, we_n}: activate 011, read 101, precharge 010, no-op 111; no other value ever appears.
- R7: The activate address is lfsr[12:0]. The read address has bits [9:0] = lfsr[15:6], bit 10 = 1 in four-bank mode (auto-precharge) and 0 in one-bank mode, and bits [12:11] = 0. The precharge address is all zeros.
- R8: The LFSR resets to 16'hACE1 and steps as {s[14:0], s[15]^s[13]^s[12]^s[10]} exactly once per loop, on the last slot; it carries over across runs.
- R9: On no-op slots the bank is held. The address is held in four-bank mode and bit-inverted every clock in one-bank mode.
- R10: Every read command XORs data_o with 16'h5555; data_o is unchanged on every other cycle.
- R11: A stop_i pulse ends the run at the end of the current loop, after which the outputs hold no-op with address, bank and data unchanged. start_i, mode_i and bin_i are ignored while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run when idle |
| stop_i | input | 1 | Finish the current loop, then stop |
| mode_i | input | 1 | 1 = four-bank interleave, 0 = one-bank |
| bin_i | input | 1 | One-bank loop length: 0 = 9 clocks, 1 = 10 clocks |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Row/column address, bit 10 = auto-precharge on reads |
| data_o | output | DATA_W | Toggling data pattern |

## Verification
Some properties are checked on every cycle: the command pins are always legal, and the address is frozen on four-bank no-ops and inverted on one-bank no-ops. Reads in four-bank mode always carry auto-precharge, data toggles by exactly half its width on reads and holds otherwise, and the bus rests on no-op when idle. The slot order of each loop, the LFSR-derived addresses, the start latency and the point at which stop takes effect can only be shown by the bench. It compares every slot of directed and random runs against its own slot tables and LFSR model.

// File: rtl/idd_seq_pkg.sv
package idd_seq_pkg;
  localparam int LFSR_W = 16;
  localparam int CNT_W  = 4;
  localparam int AP_BIT = 10;

  typedef enum logic [1:0] {CMD_NOP, CMD_ACT, CMD_RD, CMD_PRE} cmd_e;

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_pins(cmd_e c);
    case (c)
      CMD_ACT: cmd_pins = 3'b011;
      CMD_RD:  cmd_pins = 3'b101;
      CMD_PRE: cmd_pins = 3'b010;
      default: cmd_pins = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/idd_lfsr.sv
module idd_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic fb;
  assign fb = state_o[15] ^ state_o[13] ^ state_o[12] ^ state_o[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= SEED;
    else if (step_i) state_o <= {state_o[W-2:0], fb};
  end
endmodule

// File: rtl/idd_slot_map.sv
module idd_slot_map
  import idd_seq_pkg::*;
(
  input  logic             four_bank_i,
  input  logic             long_i,
  input  logic [CNT_W-1:0] idx_i,
  output cmd_e             cmd_o,
  output logic [1:0]       bank_o,
  output logic             last_o
);
  logic [CNT_W-1:0] len_m1;
  logic [CNT_W-1:0] rd_off;

  assign len_m1 = (four_bank_i || long_i) ? CNT_W'(9) : CNT_W'(8);
  assign last_o = (idx_i == len_m1);
  assign rd_off = idx_i - CNT_W'(3);

  always_comb begin
    cmd_o  = CMD_NOP;
    bank_o = 2'd0;
    if (four_bank_i) begin
      // activates on even slots 0..6, reads on odd slots 3..9
      if (!idx_i[0] && idx_i <= CNT_W'(6)) begin
        cmd_o  = CMD_ACT;
        bank_o = idx_i[2:1];
      end else if (idx_i[0] && idx_i >= CNT_W'(3)) begin
        cmd_o  = CMD_RD;
        bank_o = rd_off[2:1];
      end
    end else begin
      if (idx_i == CNT_W'(0))                         cmd_o = CMD_ACT;
      else if (idx_i == CNT_W'(3))                    cmd_o = CMD_RD;
      else if (idx_i == (long_i ? CNT_W'(7) : CNT_W'(6))) cmd_o = CMD_PRE;
    end
  end
endmodule

// File: rtl/idd_cmd_seq.sv
module idd_cmd_seq
  import idd_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int COL_W  = 10,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              mode_i,
  input  logic              bin_i,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] HALF_MASK = {(DATA_W/2){2'b01}};

  logic             run_q, mode_q, bin_q, stop_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LFSR_W-1:0] lfsr;
  cmd_e             slot_cmd;
  logic [1:0]       slot_bank;
  logic             slot_last;
  logic [ADDR_W-1:0] row_addr, rd_addr;

  idd_slot_map i_map (
    .four_bank_i(mode_q),
    .long_i     (bin_q),
    .idx_i      (cnt_q),
    .cmd_o      (slot_cmd),
    .bank_o     (slot_bank),
    .last_o     (slot_last)
  );

  idd_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) i_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (run_q && slot_last),
    .state_o(lfsr)
  );

  always_comb begin
    row_addr = lfsr[ADDR_W-1:0];
    rd_addr  = '0;
    rd_addr[COL_W-1:0] = lfsr[LFSR_W-1 -: COL_W];
    rd_addr[AP_BIT]    = mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
      bin_q  <= 1'b0;
      stop_q <= 1'b0;
      cnt_q  <= '0;
      {ras_n_o, cas_n_o, we_n_o} <= 3'b111;
      ba_o   <= '0;
      addr_o <= '0;
      data_o <= '0;
    end else if (run_q) begin
      {ras_n_o, cas_n_o, we_n_o} <= cmd_pins(slot_cmd);
      case (slot_cmd)
        CMD_ACT: begin
          ba_o   <= slot_bank;
          addr_o <= row_addr;
        end
        CMD_RD: begin
          ba_o   <= slot_bank;
          addr_o <= rd_addr;
          data_o <= data_o ^ HALF_MASK;
        end
        CMD_PRE: begin
          ba_o   <= slot_bank;
          addr_o <= '0;
        end
        default: if (!mode_q) addr_o <= ~addr_o;
      endcase
      if (slot_last) begin
        cnt_q <= '0;
        if (stop_q || stop_i) begin
          run_q  <= 1'b0;
          stop_q <= 1'b0;
        end
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
        stop_q <= stop_q | stop_i;
      end
    end else begin
      {ras_n_o, cas_n_o, we_n_o} <= 3'b111;
      if (start_i) begin
        run_q  <= 1'b1;
        cnt_q  <= '0;
        mode_q <= mode_i;
        bin_q  <= bin_i;
        stop_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/idd_cmd_seq_chk.sv
module idd_cmd_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_n_i,
  input logic              cas_n_i,
  input logic              we_n_i,
  input logic [1:0]        ba_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] data_i,
  input logic              run_i,
  input logic              mode_i
);
  logic [2:0] pins;
  logic       nop, rd;
  assign pins = {ras_n_i, cas_n_i, we_n_i};
  assign nop  = (pins == 3'b111);
  assign rd   = (pins == 3'b101);

  // R6
  cmd_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins inside {3'b011, 3'b101, 3'b010, 3'b111});

  // R11
  idle_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !$past(run_i)) |-> nop);

  // R9
  four_bank_nop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nop && mode_i) |-> ($stable(addr_i) && $stable(ba_i)));

  // R9
  one_bank_nop_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nop && !mode_i && $past(run_i)) |-> (addr_i == ~$past(addr_i) && $stable(ba_i)));

  // R7
  auto_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && mode_i) |-> addr_i[10]);

  // R10
  data_half_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |-> ($countones(data_i ^ $past(data_i)) == DATA_W/2));

  // R10
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> $stable(data_i));
endmodule

bind idd_cmd_seq idd_cmd_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ras_n_i(ras_n_o),
  .cas_n_i(cas_n_o),
  .we_n_i (we_n_o),
  .ba_i   (ba_o),
  .addr_i (addr_o),
  .data_i (data_o),
  .run_i  (run_q),
  .mode_i (mode_q)
);

// File: tb/test_idd_cmd_seq.sv
module test_idd_cmd_seq;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, mode = 1'b0, bin = 1'b0;
  logic ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [15:0] data;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  logic [12:0] m_addr = '0;
  logic [1:0]  m_ba = '0;
  logic [15:0] m_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idd_cmd_seq i_idd_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .mode_i(mode), .bin_i(bin), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .data_o(data)
  );

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // slot tables: 0 nop, 1 act, 2 read, 3 precharge; returns {cmd, bank}
  function automatic logic [3:0] slot(bit four, bit lng, int i);
    logic [1:0] c [10];
    logic [1:0] b [10];
    if (four) begin
      c = '{1,0,1,2,1,2,1,2,0,2};
      b = '{0,0,1,0,2,1,3,2,0,3};
    end else begin
      b = '{default: 0};
      if (lng) c = '{1,0,0,2,0,0,0,3,0,0};
      else     c = '{1,0,0,2,0,0,3,0,0,0};
    end
    return {c[i], b[i]};
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string ptag, string atag);
    chk(ptag, "pins", {13'd0, ras_n, cas_n, we_n}, {13'd0, pins_of_last});
    chk(ptag, "bank", {14'd0, ba}, {14'd0, m_ba});
    chk(atag, "addr", {3'd0, addr}, {3'd0, m_addr});
    chk("R10", "data", data, m_data);
  endtask

  logic [2:0] pins_of_last = 3'b111;

  task automatic run_seq(bit four, bit lng, int nloops, int stop_slot, bit poke);
    int len = (four || lng) ? 10 : 9;
    string ptag = four ? "R3 R6" : (lng ? "R5 R6" : "R4 R6");
    @(negedge clk);
    start = 1'b1; mode = four; bin = lng;
    @(negedge clk);
    start = 1'b0; mode = $urandom_range(0, 1); bin = $urandom_range(0, 1);
    pins_of_last = 3'b111;
    chk_all("R2", "R2");
    for (int l = 0; l < nloops; l++) begin
      for (int s = 0; s < len; s++) begin
        logic [3:0] e;
        @(negedge clk);
        e = slot(four, lng, s);
        case (e[3:2])
          2'd1: begin pins_of_last = 3'b011; m_ba = e[1:0]; m_addr = m_lfsr[12:0]; end
          2'd2: begin
            pins_of_last = 3'b101; m_ba = e[1:0];
            m_addr = {2'b00, four, m_lfsr[15:6]}; m_data = m_data ^ 16'h5555;
          end
          2'd3: begin pins_of_last = 3'b010; m_ba = e[1:0]; m_addr = '0; end
          default: begin pins_of_last = 3'b111; if (!four) m_addr = ~m_addr; end
        endcase
        chk_all(ptag, (e[3:2] == 2'd0) ? "R9" : "R7 R8");
        stop  = (l == nloops - 1) && (s == stop_slot);
        start = poke && (l == 0) && (s == 2);
        mode  = $urandom_range(0, 1);
        bin   = $urandom_range(0, 1);
      end
      m_lfsr = lfsr_next(m_lfsr);
    end
    stop = 1'b0; start = 1'b0;
    pins_of_last = 3'b111;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_all("R11", "R11");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk_all("R1", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1", "R1");
    // stop ignored while idle
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
    chk_all("R11", "R11");
    run_seq(1'b1, 1'b0, 2, 8, 1'b1);
    run_seq(1'b0, 1'b0, 2, 0, 1'b1);
    run_seq(1'b0, 1'b1, 2, 5, 1'b0);
    run_seq(1'b1, 1'b1, 1, 0, 1'b0);
    for (int r = 0; r < 8; r++) begin
      bit f = $urandom_range(0, 1);
      bit g = $urandom_range(0, 1);
      int n = $urandom_range(1, 3);
      int len = (f || g) ? 10 : 9;
      run_seq(f, g, n, $urandom_range(0, len - 2), $urandom_range(0, 1));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule